// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block collects up to 32 interrupt source lines, adds a software-raised bit for each line, and forms two views of the result. The first view is the set of lines that are pending and enabled. The OR of that set drives one combined request into an upstream primary interrupt controller. The second view is a direct-route mask. It lets chosen lines skip the aggregation and appear on the primary controller input with the same index.

Software sees the block as a small register file of 32-bit words with byte offsets. The enable mask, the software bits and the direct-route mask each have a set port and a clear port. Writing a one changes that bit, and writing a zero leaves it alone, so no read-modify-write sequence is needed. Register writes take effect at the next rising clock edge. The read data and both outputs are combinational functions of the stored state and of the source lines.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted, the enable mask and the software bits are all zero and the direct-route mask holds 0x7FE00000, so lines 21 to 30 are routed. Reads show exactly these values.
- R2: A read at offset 0x04 returns the pending view: the source lines ORed with the software bits.
- R3: A read at offset 0x00 returns the pending view ANDed with the enable mask.
- R4: A write to offset 0x08 sets each enable bit whose data bit is one and leaves the other enable bits unchanged. A read at 0x08 returns the enable mask.
- R5: A write to offset 0x0C clears each enable bit whose data bit is one and leaves the other enable bits unchanged. A read at 0x0C returns zero.
- R6: A write to offset 0x10 sets the matching software bits, and a read there returns them. A write to offset 0x14 clears the matching software bits, and a read there returns zero.
- R7: A write to offset 0x20 sets the matching direct-route bits, and a read there returns the mask. A write to offset 0x24 clears the matching direct-route bits, and a read there returns zero.
- R8: `irq_o` is high exactly when at least one bit of the enabled pending view is set.
- R9: `pass_o` equals the pending view ANDed with the direct-route mask.
- R10: Reads at any other offset return zero. Writes to any other offset change no state, and neither does a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source lines, level sensitive, already synchronised |
| wr_en_i | input | 1 | Write strobe for the register file |
| addr_i | input | ADDR_W | Byte offset for reads and writes |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined request to the primary controller |
| pass_o | output | NUM_SRC | Directly routed lines, one per primary input |

## Verification
The assertions assume that `wr_en_i`, `addr_i` and `wdata_i` hold known values at every rising edge. They also assume that a write lands only when the strobe is high. The bench drives every input on the falling edge, so each write is seen at exactly one rising edge. Random writes use word-aligned offsets across the whole address space. The source lines change only between checks, so the pending view stays steady while the register file is read back.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned OFS_STAT    = 'h00;
  localparam int unsigned OFS_RAW     = 'h04;
  localparam int unsigned OFS_EN_SET  = 'h08;
  localparam int unsigned OFS_EN_CLR  = 'h0C;
  localparam int unsigned OFS_SW_SET  = 'h10;
  localparam int unsigned OFS_SW_CLR  = 'h14;
  localparam int unsigned OFS_PT_SET  = 'h20;
  localparam int unsigned OFS_PT_CLR  = 'h24;
  localparam logic [31:0] PT_RST_DFLT = 32'h7FE0_0000;
endpackage

// File: rtl/sic_setclr_reg.sv
module sic_setclr_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= RST_VAL;
    else if (set_en_i) q_o <= q_o | bits_i;
    else if (clr_en_i) q_o <= q_o & ~bits_i;
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] soft_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] pass_mask_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o,
  output logic [W-1:0] pass_o
);
  assign raw_o    = src_i | soft_i;
  assign masked_o = raw_o & en_i;
  assign irq_o    = |masked_o;
  assign pass_o   = raw_o & pass_mask_i;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter logic [NUM_SRC-1:0] PT_RST = NUM_SRC'(PT_RST_DFLT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] pass_o
);
  localparam int unsigned NREG = 3;
  localparam int unsigned R_EN = 0, R_SW = 1, R_PT = 2;

  logic [NREG-1:0]    set_en, clr_en;
  logic [NUM_SRC-1:0] en_q, soft_q, pass_q, raw, masked;

  always_comb begin
    set_en = '0;
    clr_en = '0;
    if (wr_en_i) begin
      set_en[R_EN] = addr_i == ADDR_W'(OFS_EN_SET);
      clr_en[R_EN] = addr_i == ADDR_W'(OFS_EN_CLR);
      set_en[R_SW] = addr_i == ADDR_W'(OFS_SW_SET);
      clr_en[R_SW] = addr_i == ADDR_W'(OFS_SW_CLR);
      set_en[R_PT] = addr_i == ADDR_W'(OFS_PT_SET);
      clr_en[R_PT] = addr_i == ADDR_W'(OFS_PT_CLR);
    end
  end

  sic_setclr_reg #(.W(NUM_SRC), .RST_VAL('0)) i_en_reg (
    .clk_i, .rst_ni, .set_en_i(set_en[R_EN]), .clr_en_i(clr_en[R_EN]),
    .bits_i(wdata_i), .q_o(en_q));

  sic_setclr_reg #(.W(NUM_SRC), .RST_VAL('0)) i_sw_reg (
    .clk_i, .rst_ni, .set_en_i(set_en[R_SW]), .clr_en_i(clr_en[R_SW]),
    .bits_i(wdata_i), .q_o(soft_q));

  sic_setclr_reg #(.W(NUM_SRC), .RST_VAL(PT_RST)) i_pt_reg (
    .clk_i, .rst_ni, .set_en_i(set_en[R_PT]), .clr_en_i(clr_en[R_PT]),
    .bits_i(wdata_i), .q_o(pass_q));

  sic_route #(.W(NUM_SRC)) i_route (
    .src_i, .soft_i(soft_q), .en_i(en_q), .pass_mask_i(pass_q),
    .raw_o(raw), .masked_o(masked), .irq_o, .pass_o);

  // write-only and unmapped offsets read as zero
  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(OFS_STAT))   rdata_o = masked;
    else if (addr_i == ADDR_W'(OFS_RAW))    rdata_o = raw;
    else if (addr_i == ADDR_W'(OFS_EN_SET)) rdata_o = en_q;
    else if (addr_i == ADDR_W'(OFS_SW_SET)) rdata_o = soft_q;
    else if (addr_i == ADDR_W'(OFS_PT_SET)) rdata_o = pass_q;
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pass_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] soft_q,
  input logic [NUM_SRC-1:0] pass_q
);
  logic wr_ens, wr_enc, wr_sws, wr_ptc;
  assign wr_ens = wr_en_i && addr_i == ADDR_W'(OFS_EN_SET);
  assign wr_enc = wr_en_i && addr_i == ADDR_W'(OFS_EN_CLR);
  assign wr_sws = wr_en_i && addr_i == ADDR_W'(OFS_SW_SET);
  assign wr_ptc = wr_en_i && addr_i == ADDR_W'(OFS_PT_CLR);

  assert_en_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ens |=> (en_q & $past(wdata_i)) == $past(wdata_i));
  assert_en_set_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ens |=> (en_q & $past(en_q)) == $past(en_q));
  assert_en_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_enc |=> (en_q & $past(wdata_i)) == '0);
  assert_sw_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sws |=> (soft_q & $past(wdata_i)) == $past(wdata_i));
  assert_pt_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptc |=> (pass_q & $past(wdata_i)) == '0);
  assert_irq_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  assert_pass_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o & ~pass_q) == '0);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q) && $stable(soft_q) && $stable(pass_q));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int N = 32;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [N-1:0]  wdata_i = '0;
  logic [N-1:0]  rdata_o, pass_o;
  logic          irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] m_en, m_sw, m_pt;

  always #5 clk_i = ~clk_i;

  irq_aggregator i_irq_aggregator (.*);

  function automatic logic [N-1:0] exp_rd(int a);
    case (a)
      'h00: return (src_i | m_sw) & m_en;
      'h04: return src_i | m_sw;
      'h08: return m_en;
      'h10: return m_sw;
      'h20: return m_pt;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      'h00: return "R3";
      'h04: return "R2";
      'h08: return "R4";
      'h0C: return "R5";
      'h10, 'h14: return "R6";
      'h20, 'h24: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string rq, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic check_all();
    for (int a = 0; a < 64; a += 4) begin
      addr_i = AW'(a);
      #1;
      chk(req_of(a), rdata_o, exp_rd(a));
    end
    chk("R8", N'(irq_o), N'(|((src_i | m_sw) & m_en)));
    chk("R9", pass_o, (src_i | m_sw) & m_pt);
  endtask

  task automatic wr(int a, logic [N-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (a)
      'h08: m_en |= d;
      'h0C: m_en &= ~d;
      'h10: m_sw |= d;
      'h14: m_sw &= ~d;
      'h20: m_pt |= d;
      'h24: m_pt &= ~d;
      default: ;
    endcase
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_en = '0; m_sw = '0; m_pt = 32'h7FE0_0000;
    #12;
    // R1: reset values
    src_i = '0;
    check_all();
    chk("R1", pass_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R9: default route with sources
    src_i = 32'hFFFF_FFFF;
    #1; chk("R1", pass_o, 32'h7FE0_0000);
    chk("R8", N'(irq_o), '0);
    // R4/R5 directed: set with zeros keeps bits
    wr('h08, 32'h0000_00F0); wr('h08, 32'h0000_0001); check_all();
    wr('h0C, 32'h0000_0030); check_all();
    // R6: software bit raises irq with no source
    src_i = '0;
    wr('h10, 32'h0000_0080); check_all();
    wr('h14, 32'h0000_0080); check_all();
    // R7: route a low line, drop a default one
    wr('h20, 32'h0000_0003); wr('h24, 32'h0020_0000);
    src_i = 32'h0020_0003; check_all();
    // R10: writes to read-only and unmapped offsets
    wr('h00, '1); wr('h04, '1); wr('h18, '1); wr('h3C, '1); check_all();
    // random
    for (int i = 0; i < 600; i++) begin
      wr(int'($urandom % 16) * 4, $urandom & $urandom);
      if ($urandom % 3 == 0) src_i = $urandom & $urandom;
      check_all();
    end
    // R1: reset again after activity
    @(negedge clk_i); rst_ni = 1'b0;
    m_en = '0; m_sw = '0; m_pt = 32'h7FE0_0000;
    check_all();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule